// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block sits beside a shared two-port RAM and turns the two topmost words of the address space into mailboxes. Each port owns one of these words. When the other side writes a message into it, the owner gets an interrupt. The owner acknowledges the interrupt by reading its own mailbox. The block only watches the access controls of both ports. The message itself stays in the RAM, and the arbitration that produces the per-port busy flags is done elsewhere.

Port A owns the word just below the top of memory, and port B owns the topmost word. Both flags are kept in registers and cleared by reset. The interrupt outputs are active-low and change on the clock edge that samples the qualifying access. An active busy flag on a port stops that port from posting to its peer and also stops it from acknowledging its own interrupt.

Top module: `mbx_irq_top`

## Requirements
- R1: After reset is released, both pa_irq_n and pb_irq_n are high (no interrupt pending).
- R2: A port-A write (pa_sel=1, pa_wr=1, pa_busy=0) to address all-ones drives pb_irq_n low at the next clock edge.
- R3: A port-B write (pb_sel=1, pb_wr=1, pb_busy=0) to address all-ones minus one drives pa_irq_n low at the next clock edge.
- R4: An owner read of its own mailbox (sel=1, oe=1, wr=0, busy=0; port A at all-ones minus one, port B at all-ones) returns that port's irq_n to high at the next clock edge.
- R5: A read by one port of the other port's mailbox leaves the other port's interrupt unchanged.
- R6: A write to the peer's mailbox made while the writing port's busy is high does not raise the peer's interrupt.
- R7: A read of its own mailbox made while the owner's busy is high does not clear the owner's interrupt.
- R8: A read counts only when sel and oe are both 1 and wr is 0. A write counts only when sel and wr are both 1. Any other combination neither sets nor clears a flag.
- R9: If one flag is both set and cleared in the same cycle, the set wins and irq_n goes low.
- R10: Accesses to any address other than the two mailboxes, and writes by a port to its own mailbox, have no effect on either interrupt.
- R11: Without a qualifying set or clear, each interrupt output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pa_sel | input | 1 | Port A chip select, active high |
| pa_wr | input | 1 | Port A write strobe, active high |
| pa_oe | input | 1 | Port A output enable, active high |
| pa_busy | input | 1 | Port A lost arbitration, active high |
| pa_addr | input | ADDR_W | Port A address |
| pb_sel | input | 1 | Port B chip select, active high |
| pb_wr | input | 1 | Port B write strobe, active high |
| pb_oe | input | 1 | Port B output enable, active high |
| pb_busy | input | 1 | Port B lost arbitration, active high |
| pb_addr | input | ADDR_W | Port B address |
| pa_irq_n | output | 1 | Interrupt to port A, active low |
| pb_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The bench builds the block with ADDR_W set to 3. With only eight addresses, both mailboxes and six ordinary words fit in one sweep. This makes it possible to step through every combination of both ports' addresses and control bits (16384 cycles), with the flags carried from one cycle into the next. The sweep therefore reaches collisions of set and clear, busy-blocked accesses, and partial enables in both flag states. A directed sequence after the sweep then checks holding, peer reads and own-mailbox writes at known flag values.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Port index convention: 0 = port A (owns all-ones minus one),
  // 1 = port B (owns all-ones).
  localparam int unsigned NUM_PORTS = 2;

  typedef struct packed {
    logic post_peer;  // qualified write into the other port's mailbox
    logic ack_own;    // qualified read of this port's own mailbox
  } mbx_evt_t;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] sync_q;
  logic [NS-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[NS-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[NS-1];

endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]    OWN_MBX  = '1,
  parameter logic [ADDR_W-1:0]    PEER_MBX = '0
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output mbx_evt_t          evt
);

  logic is_write;
  logic is_read;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    is_write      = sel & wr;
    is_read       = sel & oe & ~wr;
    hit_own       = (addr == OWN_MBX);
    hit_peer      = (addr == PEER_MBX);
    evt.post_peer = is_write & hit_peer & ~busy;
    evt.ack_own   = is_read  & hit_own  & ~busy;
  end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_ok,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;  // set dominates a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign irq_n_o = ~flag_q;

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pa_sel,
  input  logic              pa_wr,
  input  logic              pa_oe,
  input  logic              pa_busy,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic              pb_sel,
  input  logic              pb_wr,
  input  logic              pb_oe,
  input  logic              pb_busy,
  input  logic [ADDR_W-1:0] pb_addr,
  output logic              pa_irq_n,
  output logic              pb_irq_n
);

  localparam logic [ADDR_W-1:0] MBX_HI = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBX_LO = MBX_HI - 1'b1;

  logic rst_ok;

  logic              p_sel  [NUM_PORTS];
  logic              p_wr   [NUM_PORTS];
  logic              p_oe   [NUM_PORTS];
  logic              p_busy [NUM_PORTS];
  logic [ADDR_W-1:0] p_addr [NUM_PORTS];
  mbx_evt_t          p_evt  [NUM_PORTS];
  logic              p_irqn [NUM_PORTS];

  always_comb begin
    p_sel[0]  = pa_sel;   p_sel[1]  = pb_sel;
    p_wr[0]   = pa_wr;    p_wr[1]   = pb_wr;
    p_oe[0]   = pa_oe;    p_oe[1]   = pb_oe;
    p_busy[0] = pa_busy;  p_busy[1] = pb_busy;
    p_addr[0] = pa_addr;  p_addr[1] = pb_addr;
  end

  mbx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned    PEER  = NUM_PORTS - 1 - p;
    localparam logic [ADDR_W-1:0] OWN_A  = (p == 0) ? MBX_LO : MBX_HI;
    localparam logic [ADDR_W-1:0] PEER_A = (p == 0) ? MBX_HI : MBX_LO;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_MBX  (OWN_A),
      .PEER_MBX (PEER_A)
    ) u_dec (
      .sel  (p_sel[p]),
      .wr   (p_wr[p]),
      .oe   (p_oe[p]),
      .busy (p_busy[p]),
      .addr (p_addr[p]),
      .evt  (p_evt[p])
    );

    mbx_irq_flag u_flag (
      .clk     (clk),
      .rst_ok  (rst_ok),
      .set_i   (p_evt[PEER].post_peer),
      .clr_i   (p_evt[p].ack_own),
      .irq_n_o (p_irqn[p])
    );
  end

  assign pa_irq_n = p_irqn[0];
  assign pb_irq_n = p_irqn[1];

  // Checks relating port stimulus to the registered interrupt outputs.

  // R1: outputs idle while reset is held in the synchronizer
  always_comb begin
    if (!rst_ok) begin
      assert_reset_idle_R1: assert (pa_irq_n && pb_irq_n);
    end
  end

  // R2 and R9: qualified A write to the top word raises B's interrupt
  assert_post_to_b_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (pa_sel && pa_wr && !pa_busy && pa_addr == MBX_HI) |=> !pb_irq_n);

  // R3: qualified B write to the word below the top raises A's interrupt
  assert_post_to_a_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (pb_sel && pb_wr && !pb_busy && pb_addr == MBX_LO) |=> !pa_irq_n);

  // R4: owner acknowledge without a competing post clears the flag
  assert_ack_b_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (pb_sel && pb_oe && !pb_wr && !pb_busy && pb_addr == MBX_HI &&
     !(pa_sel && pa_wr && !pa_busy && pa_addr == MBX_HI)) |=> pb_irq_n);

  // R6: a busy port A can never raise B's interrupt (only A posts to B)
  assert_busy_post_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (pb_irq_n && pa_busy) |=> pb_irq_n);

  // R7: a busy port B cannot drop its own pending interrupt
  assert_busy_ack_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (!pb_irq_n && pb_busy) |=> !pb_irq_n);

  // R11: with both ports deselected nothing changes
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (!pa_sel && !pb_sel) |=> ($stable(pa_irq_n) && $stable(pb_irq_n)));

endmodule

// File: tb/mbx_irq_top_test.sv
`timescale 1ns/1ps
module mbx_irq_top_test;

  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] HI = 3'd7;
  localparam logic [AW-1:0] LO = 3'd6;

  logic clk = 1'b0;
  logic rst_n;
  logic pa_sel, pa_wr, pa_oe, pa_busy;
  logic pb_sel, pb_wr, pb_oe, pb_busy;
  logic [AW-1:0] pa_addr, pb_addr;
  logic pa_irq_n, pb_irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_a  = 0;  // expected pending flag (1 = interrupt asserted)
  bit exp_b  = 0;

  always #2 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .pa_sel(pa_sel), .pa_wr(pa_wr), .pa_oe(pa_oe), .pa_busy(pa_busy), .pa_addr(pa_addr),
    .pb_sel(pb_sel), .pb_wr(pb_wr), .pb_oe(pb_oe), .pb_busy(pb_busy), .pb_addr(pb_addr),
    .pa_irq_n(pa_irq_n), .pb_irq_n(pb_irq_n)
  );

  // access code: {sel, wr, oe, busy, addr[2:0]}
  function automatic logic [6:0] wr_c(input logic [2:0] ad);
    return {4'b1100, ad};
  endfunction
  function automatic logic [6:0] rd_c(input logic [2:0] ad);
    return {4'b1010, ad};
  endfunction
  localparam logic [6:0] IDLE = 7'd0;
  localparam logic [6:0] BUSY = 7'b0001000;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic bit is_wr(input logic [6:0] c, input logic [2:0] ad);
    return c[6] && c[5] && c[2:0] == ad;
  endfunction
  function automatic bit is_rd(input logic [6:0] c, input logic [2:0] ad);
    return c[6] && c[4] && !c[5] && c[2:0] == ad;
  endfunction

  // Reason label for the flag owned at address own, posted by writer code w
  function automatic string why(input logic [6:0] w, input logic [6:0] o,
                                input logic [2:0] own, input string set_tag);
    if (is_wr(w, own)) begin
      if (w[3]) return "R6";
      if (is_rd(o, own) && !o[3]) return "R9";
      return set_tag;
    end
    if (is_rd(o, own)) return o[3] ? "R7" : "R4";
    if (is_rd(w, own)) return "R5";
    if ((o[6] || o[4]) && o[2:0] == own) return "R8";
    if ((w[6] || w[5]) && w[2:0] == own) return "R8";
    return "R10";
  endfunction

  // One cycle: drive at negedge, model next state, check at next negedge
  task automatic step(input logic [6:0] a, input logic [6:0] b);
    bit set_a, clr_a, set_b, clr_b;
    string ta, tb_;
    {pa_sel, pa_wr, pa_oe, pa_busy, pa_addr} = a;
    {pb_sel, pb_wr, pb_oe, pb_busy, pb_addr} = b;
    set_b = is_wr(a, HI) && !a[3];
    clr_b = is_rd(b, HI) && !b[3];
    set_a = is_wr(b, LO) && !b[3];
    clr_a = is_rd(a, LO) && !a[3];
    ta  = why(b, a, LO, "R3");
    tb_ = why(a, b, HI, "R2");
    if (set_a) exp_a = 1; else if (clr_a) exp_a = 0;
    if (set_b) exp_b = 1; else if (clr_b) exp_b = 0;
    @(negedge clk);
    check(pa_irq_n, ~exp_a, ta, $sformatf("pa_irq_n a=%h b=%h", a, b));
    check(pb_irq_n, ~exp_b, tb_, $sformatf("pb_irq_n a=%h b=%h", a, b));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {pa_sel, pa_wr, pa_oe, pa_busy, pa_addr} = IDLE;
    {pb_sel, pb_wr, pb_oe, pb_busy, pb_addr} = IDLE;
    repeat (3) @(negedge clk);
    check(pa_irq_n, 1'b1, "R1", "pa_irq_n in reset");
    check(pb_irq_n, 1'b1, "R1", "pb_irq_n in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pa_irq_n, 1'b1, "R1", "pa_irq_n after release");
    check(pb_irq_n, 1'b1, "R1", "pb_irq_n after release");

    // Exhaustive sweep over both ports' controls and addresses
    for (int i = 0; i < (1 << 14); i++) begin
      step(i[6:0], i[13:7]);
    end

    // Directed sequence at known flag values
    step(rd_c(LO), rd_c(HI));
    check(pa_irq_n, 1'b1, "R4", "A ack own");
    check(pb_irq_n, 1'b1, "R4", "B ack own");
    step(wr_c(HI), IDLE);
    check(pb_irq_n, 1'b0, "R2", "A posts to B");
    for (int k = 0; k < 3; k++) begin
      step(IDLE, IDLE);
      check(pb_irq_n, 1'b0, "R11", "B holds pending");
    end
    step(rd_c(HI), IDLE);
    check(pb_irq_n, 1'b0, "R5", "A reads B mailbox");
    step(IDLE, rd_c(HI) | BUSY);
    check(pb_irq_n, 1'b0, "R7", "busy B ack");
    step(IDLE, {4'b1000, HI});
    check(pb_irq_n, 1'b0, "R8", "B sel without oe");
    step(IDLE, {4'b0010, HI});
    check(pb_irq_n, 1'b0, "R8", "B oe without sel");
    step(IDLE, {4'b1110, HI});
    check(pb_irq_n, 1'b0, "R8", "B write with oe is no ack");
    step(IDLE, rd_c(HI));
    check(pb_irq_n, 1'b1, "R4", "B ack clears");
    step(wr_c(HI) | BUSY, IDLE);
    check(pb_irq_n, 1'b1, "R6", "busy A post blocked");
    step(wr_c(HI), rd_c(HI));
    check(pb_irq_n, 1'b0, "R9", "set beats clear");
    step(IDLE, wr_c(LO));
    check(pa_irq_n, 1'b0, "R3", "B posts to A");
    step(rd_c(LO), rd_c(HI));
    check(pa_irq_n, 1'b1, "R4", "A ack");
    step(wr_c(LO), wr_c(HI));
    check(pa_irq_n, 1'b1, "R10", "A writes own mailbox");
    check(pb_irq_n, 1'b1, "R10", "B writes own mailbox");
    step(wr_c(3'd5), wr_c(3'd5));
    check(pa_irq_n, 1'b1, "R10", "other address");
    check(pb_irq_n, 1'b1, "R10", "other address");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule